// File: doc/BRIEF.md
# Polled Character I/O Port

This block is a small bus slave that gives a processor access to a keyboard and a character display through four byte-wide registers. On the device side, the keyboard presents a character together with a one-cycle strobe. The display takes outgoing characters through a valid/accept handshake. On the processor side, a plain bus carries a register index, read and write strobes, write data and registered read data. Software drives the port by polling: it loops on a ready flag and then moves one byte.

Each direction has one ready flag. A device event sets the flag, and a processor access to the matching data register clears it. The keyboard flag starts low, meaning no character has arrived yet. The display flag starts high, meaning the display buffer is free. A keyboard character that arrives before software has taken the previous one replaces that character and sets a sticky overrun bit. Reading the keyboard data register clears both the ready flag and the overrun bit.

Register indices are 0 for keyboard data, 1 for keyboard status, 2 for display data and 3 for display status. In both status registers the ready flag sits at bit 3. The keyboard status register also carries overrun at bit 0.

Top module: `chario_port`

## Requirements
- R1: After reset, the keyboard status register (index 1) reads 0x00, the display status register (index 3) reads 0x08, and disp_valid is 0.
- R2: A kbd_strobe loads kbd_char into the keyboard data register (index 0) and sets the keyboard ready flag (bit 3 of index 1). A read of index 0 returns that character and clears the flag.
- R3: A kbd_strobe that arrives while the keyboard ready flag is 1 overwrites the held character and sets overrun (bit 0 of index 1). The next read of index 0 returns the newest character and clears both overrun and the ready flag.
- R4: A write to the display data register (index 2) latches the byte onto disp_char, clears the display ready flag (bit 3 of index 3) and raises disp_valid in the following cycle.
- R5: disp_accept while disp_valid is 1 sets the display ready flag and drops disp_valid. disp_accept while disp_valid is 0 changes nothing.
- R6: All status bits other than bit 3 (both status registers) and bit 0 (keyboard status only) read 0.
- R7: Writes to index 0, index 1 and index 3 change no register and no flag.
- R8: Read data appears on bus_rdata in the cycle after the bus_rd cycle. Status reads have no side effect. Indices 4 and above read 0x00.
- R9: A kbd_strobe in the same cycle as a read of index 0 returns the previously held character and leaves the ready flag set with the new character. Overrun is cleared.
- R10: A read of index 2 returns the last byte written there and leaves the display ready flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register index |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid the cycle after bus_rd |
| kbd_strobe | input | 1 | New keyboard character present |
| kbd_char | input | 8 | Keyboard character |
| disp_char | output | 8 | Character offered to the display |
| disp_valid | output | 1 | A character is waiting for the display |
| disp_accept | input | 1 | Display takes the offered character |

## Verification
Single strobes separated by reads show the basic set/clear handshake. Two strobes in a row before a read separate plain loading from overwrite with overrun. A strobe in the same cycle as a data read tells whether the clear or the set wins, and which character is returned. Writes to every non-writable index, status re-reads and accepts with nothing pending show that only the data-register accesses have side effects.

// File: rtl/chario_pkg.sv
package chario_pkg;

    localparam int CHAR_W = 8;

    typedef struct packed {
        logic [CHAR_W-1:0] ch;
        logic              rdy;
        logic              ovr;
    } kbd_state_t;

    typedef struct packed {
        logic [CHAR_W-1:0] ch;
        logic              free;
    } dsp_state_t;

endpackage

// File: rtl/chario_kbd_buf.sv
module chario_kbd_buf
    import chario_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [CHAR_W-1:0] char_in,
    input  logic              take,
    output logic [CHAR_W-1:0] char_o,
    output logic              rdy_o,
    output logic              ovr_o
);

    kbd_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take) begin
            st_d.rdy = 1'b0;
            st_d.ovr = 1'b0;
        end
        if (strobe) begin
            st_d.ch  = char_in;
            st_d.rdy = 1'b1;
            if (st_q.rdy && !take) begin
                st_d.ovr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign char_o = st_q.ch;
    assign rdy_o  = st_q.rdy;
    assign ovr_o  = st_q.ovr;

    p_strobe_sets_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> rdy_o);
    p_take_clears_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !strobe) |=> (!rdy_o && !ovr_o));
    p_overwrite_flags_overrun_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && rdy_o && !take) |=> ovr_o);
    p_same_cycle_keeps_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && take) |=> (rdy_o && !ovr_o));

endmodule

// File: rtl/chario_dsp_buf.sv
module chario_dsp_buf
    import chario_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CHAR_W-1:0] wdata,
    input  logic              accept,
    output logic [CHAR_W-1:0] char_o,
    output logic              free_o
);

    dsp_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (accept && !st_q.free) begin
            st_d.free = 1'b1;
        end
        if (load) begin
            st_d.ch   = wdata;
            st_d.free = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{ch: '0, free: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign char_o = st_q.ch;
    assign free_o = st_q.free;

    p_load_marks_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (!free_o && char_o == $past(wdata)));
    p_accept_frees_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !free_o && !load) |=> free_o);
    p_idle_holds_char_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(char_o));

endmodule

// File: rtl/chario_bus_dec.sv
module chario_bus_dec
    import chario_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int IDX_KDAT = 0,
    parameter int IDX_KST  = 1,
    parameter int IDX_DDAT = 2,
    parameter int IDX_DST  = 3,
    parameter int RDY_BIT  = 3,
    parameter int OVR_BIT  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic [CHAR_W-1:0] kbd_char,
    input  logic              kbd_rdy,
    input  logic              kbd_ovr,
    input  logic [CHAR_W-1:0] dsp_char,
    input  logic              dsp_free,
    output logic              kbd_take,
    output logic              dsp_load,
    output logic [CHAR_W-1:0] rdata
);

    localparam logic [ADDR_W-1:0] A_KDAT = ADDR_W'(IDX_KDAT);
    localparam logic [ADDR_W-1:0] A_KST  = ADDR_W'(IDX_KST);
    localparam logic [ADDR_W-1:0] A_DDAT = ADDR_W'(IDX_DDAT);
    localparam logic [ADDR_W-1:0] A_DST  = ADDR_W'(IDX_DST);
    localparam logic [CHAR_W-1:0] KST_MASK = CHAR_W'((1 << RDY_BIT) | (1 << OVR_BIT));

    logic [CHAR_W-1:0] rdata_d, rdata_q;
    logic [CHAR_W-1:0] kst_word, dst_word;
    logic              mapped;

    always_comb begin
        kst_word          = '0;
        kst_word[RDY_BIT] = kbd_rdy;
        kst_word[OVR_BIT] = kbd_ovr;
        dst_word          = '0;
        dst_word[RDY_BIT] = dsp_free;
        mapped            = (addr == A_KDAT) || (addr == A_KST) ||
                            (addr == A_DDAT) || (addr == A_DST);
        kbd_take          = rd && (addr == A_KDAT);
        dsp_load          = wr && (addr == A_DDAT);
        rdata_d           = rdata_q;
        if (rd) begin
            unique case (1'b1)
                addr == A_KDAT: rdata_d = kbd_char;
                addr == A_KST:  rdata_d = kst_word;
                addr == A_DDAT: rdata_d = dsp_char;
                addr == A_DST:  rdata_d = dst_word;
                default:        rdata_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata = rdata_q;

    p_kst_reserved_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == A_KST) |=> ((rdata & ~KST_MASK) == '0));
    p_dst_reserved_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == A_DST) |=> ((rdata & ~(CHAR_W'(1) << RDY_BIT)) == '0));
    p_unmapped_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !mapped) |=> (rdata == '0));
    p_no_read_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rdata));

endmodule

// File: rtl/chario_port.sv
module chario_port
    import chario_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              kbd_strobe,
    input  logic [7:0]        kbd_char,
    output logic [7:0]        disp_char,
    output logic              disp_valid,
    input  logic              disp_accept
);

    logic [CHAR_W-1:0] k_char, d_char;
    logic              k_rdy, k_ovr, d_free, k_take, d_load;

    chario_kbd_buf u_kbd (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (kbd_strobe),
        .char_in (kbd_char),
        .take    (k_take),
        .char_o  (k_char),
        .rdy_o   (k_rdy),
        .ovr_o   (k_ovr)
    );

    chario_dsp_buf u_dsp (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (d_load),
        .wdata  (bus_wdata),
        .accept (disp_accept),
        .char_o (d_char),
        .free_o (d_free)
    );

    chario_bus_dec #(.ADDR_W(ADDR_W)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .rd       (bus_rd),
        .wr       (bus_wr),
        .kbd_char (k_char),
        .kbd_rdy  (k_rdy),
        .kbd_ovr  (k_ovr),
        .dsp_char (d_char),
        .dsp_free (d_free),
        .kbd_take (k_take),
        .dsp_load (d_load),
        .rdata    (bus_rdata)
    );

    assign disp_char  = d_char;
    assign disp_valid = !d_free;

    p_valid_tracks_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_accept && !bus_wr) |=> !disp_valid);
    p_status_write_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr != ADDR_W'(2) && !disp_accept) |=> $stable(disp_valid));

endmodule

// File: tb/chario_port_tb.sv
module chario_port_tb_top;

    localparam time CLK_PERIOD = 10ns;
    localparam int  AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0]    bus_wdata = '0, bus_rdata;
    logic          kbd_strobe = 1'b0;
    logic [7:0]    kbd_char = '0, disp_char;
    logic          disp_valid, disp_accept = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_pend = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chario_port #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .kbd_strobe(kbd_strobe), .kbd_char(kbd_char), .disp_char(disp_char),
        .disp_valid(disp_valid), .disp_accept(disp_accept)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    // monitor: compares registered read data against the scoreboard
    always @(posedge clk) rd_pend <= bus_rd;
    always @(negedge clk) begin
        if (rd_pend) begin
            if (exp_q.size() == 0) begin
                check("scoreboard underflow", 8'h01, 8'h00);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    // driver: one bus cycle, optional keyboard strobe in the same cycle
    task automatic cyc(input logic rd, input logic wr, input int a, input logic [7:0] wd,
                       input logic stb, input logic [7:0] ch, input string tag,
                       input logic [7:0] expv);
        bus_rd = rd; bus_wr = wr; bus_addr = AW'(a); bus_wdata = wd;
        kbd_strobe = stb; kbd_char = ch;
        if (rd) begin
            exp_q.push_back(expv);
            tag_q.push_back(tag);
        end
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0; kbd_strobe = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd_reg(input int a, input string tag, input logic [7:0] expv);
        cyc(1'b1, 1'b0, a, 8'h00, 1'b0, 8'h00, tag, expv);
    endtask

    task automatic wr_reg(input int a, input logic [7:0] d);
        cyc(1'b0, 1'b1, a, d, 1'b0, 8'h00, "", 8'h00);
    endtask

    task automatic key(input logic [7:0] c);
        cyc(1'b0, 1'b0, 0, 8'h00, 1'b1, c, "", 8'h00);
    endtask

    task automatic accept_pulse();
        disp_accept = 1'b1;
        @(negedge clk);
        disp_accept = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 disp_valid", {7'b0, disp_valid}, 8'h00);
        rd_reg(1, "R1 kbd status", 8'h00);
        rd_reg(3, "R1 dsp status", 8'h08);

        // R2 single character
        key(8'h41);
        rd_reg(1, "R2 ready set", 8'h08);
        rd_reg(1, "R8 status reread no side effect", 8'h08);
        rd_reg(0, "R2 data", 8'h41);
        rd_reg(1, "R2 ready cleared", 8'h00);

        // R3 overwrite with overrun
        key(8'h42);
        key(8'h43);
        rd_reg(1, "R3 overrun and ready", 8'h09);
        rd_reg(0, "R3 newest char", 8'h43);
        rd_reg(1, "R3 overrun cleared", 8'h00);

        // R7 writes to non-writable registers
        wr_reg(1, 8'hFF);
        wr_reg(0, 8'h55);
        wr_reg(3, 8'h00);
        rd_reg(1, "R7 kbd status", 8'h00);
        rd_reg(3, "R7 dsp status", 8'h08);
        rd_reg(0, "R7 kbd data", 8'h43);
        check("R7 disp_valid", {7'b0, disp_valid}, 8'h00);

        // R4 display write, R10 readback
        wr_reg(2, 8'h5A);
        check("R4 disp_valid", {7'b0, disp_valid}, 8'h01);
        check("R4 disp_char", disp_char, 8'h5A);
        rd_reg(3, "R4 dsp busy", 8'h00);
        rd_reg(2, "R10 dsp data", 8'h5A);
        rd_reg(3, "R10 still busy", 8'h00);

        // R5 accept
        accept_pulse();
        check("R5 disp_valid low", {7'b0, disp_valid}, 8'h00);
        rd_reg(3, "R5 dsp free", 8'h08);
        accept_pulse();
        check("R5 idle accept valid", {7'b0, disp_valid}, 8'h00);
        check("R5 idle accept char", disp_char, 8'h5A);
        rd_reg(3, "R5 idle accept status", 8'h08);

        // R8 unmapped
        rd_reg(7, "R8 unmapped", 8'h00);
        rd_reg(15, "R8 unmapped top", 8'h00);

        // R9 strobe with simultaneous read, overrun pending
        key(8'h60);
        key(8'h61);
        rd_reg(1, "R9 setup overrun", 8'h09);
        cyc(1'b1, 1'b0, 0, 8'h00, 1'b1, 8'h62, "R9 old char returned", 8'h61);
        rd_reg(1, "R9 ready kept overrun cleared", 8'h08);
        rd_reg(0, "R9 new char", 8'h62);
        rd_reg(1, "R9 final", 8'h00);

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) check("scoreboard leftover", 8'(exp_q.size()), 8'h00);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule